// File: doc/BRIEF.md
# Sprite scanline composer

This block builds the sprite layer of one video line ahead of time. A pulse on `start_i` at horizontal sync names the line to build next. The block then walks the sprite attribute table from entry 0 up to a programmable highest entry. It skips entries that do not cover that line. For each entry that does, it fetches the pattern rows through a read port with one-cycle latency and writes the visible pixels into a 256-entry line buffer. Each buffer entry holds a colour index, a palette number and a priority bit. Any number of sprites may share a line.

The line buffer has two banks. One bank is filled for the coming line while the other bank is read out pixel by pixel through `rd_x_i`/`rd_pix_o` for the line being displayed. Each sprite carries its own size (8x8 or 16x16), mirroring on each axis, colour depth (1, 2 or 3 bits per pixel), palette, priority and a link flag. A linked sprite is positioned relative to the sprite evaluated just before it.

Top module: `spr_line_render`

## Requirements
- R1: Sprites 0 through `max_spr_i` (inclusive, latched at `start_i`) are evaluated and drawn, with no limit on how many share a line; entries above `max_spr_i` leave no pixels.
- R2: Attribute word: y [7:0], x [15:8], pattern [23:16], size [24] (1 = 16x16, 0 = 8x8), x-flip [25], y-flip [26], depth [28:27], palette [30:29], priority [31], link [32]. A sprite covers line L when (L - y) mod 256 is below its size.
- R3: The x-flip bit mirrors the pattern row horizontally and the y-flip bit selects row (size-1-d) instead of row d, where d = (L - y) mod 256.
- R4: Depth code 0 gives 1 plane, code 1 gives 2 planes, and codes 2 and 3 give 3 planes. Colour bit p is taken from plane p, and the planes that are not fetched read as 0.
- R5: A pixel of colour 0 is transparent unless `opaque0_i` (latched at `start_i`) is 1, in which case it is drawn.
- R6: When the link bit is set on entry i > 0, the effective x and y are the entry's own x and y plus the effective x and y of entry i-1, modulo 256. Entry 0 ignores its link bit.
- R7: Where sprites overlap, the pixel drawn by the lower-numbered sprite is kept.
- R8: Each `start_i` swaps the banks and clears the new fill bank. `rd_pix_o` shows the bank filled before the last `start_i` and does not change while the other bank is filled.
- R9: `busy_o` rises the cycle after `start_i` and falls less than 800 cycles later.
- R10: Pixels whose x (effective x plus column) exceeds 255 are dropped, and vertical coverage wraps modulo 256.
- R11: After reset, `busy_o` is 0 and every buffer entry reads 0.
- R12: `pat_addr_o` = {pattern, plane[1:0], row[3:0]}. The 16-bit word arrives on `pat_data_i` one cycle after `pat_re_o`, bit 15 being the leftmost pixel, and 8-wide sprites use bits 15:8. `pat_re_o` is asserted only while busy.
- R13: `rd_pix_o` = {drawn[6], priority[5], palette[4:3], colour[2:0]}. An entry that no sprite wrote reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | horizontal sync pulse: swap banks, begin the next line |
| line_i | input | 8 | line to build, latched at start_i |
| max_spr_i | input | 5 | highest sprite entry evaluated |
| opaque0_i | input | 1 | draw colour 0 instead of treating it as transparent |
| attr_idx_o | output | 5 | attribute entry being read |
| attr_i | input | 33 | attribute word of entry attr_idx_o, same cycle |
| pat_re_o | output | 1 | pattern read request |
| pat_addr_o | output | 14 | pattern word address |
| pat_data_i | input | 16 | pattern word, one cycle after the request |
| rd_x_i | input | 8 | display read position |
| rd_pix_o | output | 7 | display bank entry at rd_x_i |
| busy_o | output | 1 | line evaluation in progress |

## Verification
The bench targets three cases: overlap, where a design that lets later sprites overwrite shows the wrong colour; link chains, where a design that adds the raw rather than the effective parent position misplaces the third sprite; and sprites straddling the right edge or the 255-to-0 vertical wrap, where a design that wraps x or compares y without modulo arithmetic draws garbage at the left edge or loses the sprite. It also places all 32 sprites on one line and then lowers the highest entry, so a design with a hidden count limit or an off-by-one on the range loses pixels or shows extra ones. The display bank is compared on every clock while the other bank fills, so a bank swap at the wrong moment or a write into the displayed bank shows at once.

// File: rtl/spr_line_pkg.sv
package spr_line_pkg;
  localparam int COORD_W  = 8;
  localparam int LINE_PIX = 1 << COORD_W;
  localparam int ROW_W    = 4;
  localparam int PAT_W    = 16;
  localparam int MAX_PL   = 3;
  localparam int PL_W     = 2;
  localparam int NAME_W   = 8;
  localparam int PADDR_W  = NAME_W + PL_W + ROW_W;

  typedef struct packed {
    logic               link;
    logic               prio;
    logic [1:0]         pal;
    logic [1:0]         depth;
    logic               flip_y;
    logic               flip_x;
    logic               big;
    logic [NAME_W-1:0]  pat;
    logic [COORD_W-1:0] x;
    logic [COORD_W-1:0] y;
  } spr_attr_t;

  typedef struct packed {
    logic       drawn;
    logic       prio;
    logic [1:0] pal;
    logic [2:0] col;
  } pix_t;

  localparam int ATTR_W = $bits(spr_attr_t);
  localparam int PIX_W  = $bits(pix_t);
endpackage

// File: rtl/spr_line_geom.sv
module spr_line_geom
  import spr_line_pkg::*;
(
  input  spr_attr_t          attr_i,
  input  logic               link_en_i,
  input  logic [COORD_W-1:0] prev_x_i,
  input  logic [COORD_W-1:0] prev_y_i,
  input  logic [COORD_W-1:0] line_i,
  output logic [COORD_W-1:0] ex_o,
  output logic [COORD_W-1:0] ey_o,
  output logic               hit_o,
  output logic [ROW_W-1:0]   row_o
);
  logic [COORD_W-1:0] dy;
  logic               rel;

  always_comb begin
    rel   = link_en_i && attr_i.link;
    ex_o  = attr_i.x + (rel ? prev_x_i : '0);
    ey_o  = attr_i.y + (rel ? prev_y_i : '0);
    dy    = line_i - ey_o;
    hit_o = attr_i.big ? (dy < COORD_W'(16)) : (dy < COORD_W'(8));
    row_o = attr_i.flip_y ? ((attr_i.big ? ROW_W'(15) : ROW_W'(7)) - dy[ROW_W-1:0])
                          : dy[ROW_W-1:0];
  end
endmodule

// File: rtl/spr_line_pix.sv
module spr_line_pix
  import spr_line_pkg::*;
(
  input  logic [MAX_PL-1:0][PAT_W-1:0] planes_i,
  input  logic [ROW_W-1:0]             k_i,
  input  logic                         big_i,
  input  logic                         flip_x_i,
  output logic [MAX_PL-1:0]            col_o
);
  logic [ROW_W-1:0] c;
  logic [ROW_W-1:0] bit_idx;

  always_comb begin
    c       = flip_x_i ? ((big_i ? ROW_W'(15) : ROW_W'(7)) - k_i) : k_i;
    bit_idx = ROW_W'(PAT_W - 1) - c;
  end

  for (genvar p = 0; p < MAX_PL; p++) begin : g_pl
    assign col_o[p] = planes_i[p][bit_idx];
  end
endmodule

// File: rtl/spr_line_buf.sv
module spr_line_buf
  import spr_line_pkg::*;
#(
  parameter  int DEPTH = LINE_PIX,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          swap_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  pix_t          wd_i,
  output logic          occ_o,
  input  logic [AW-1:0] ra_i,
  output pix_t          rd_o,
  output logic          bank_o
);
  pix_t mem [2][DEPTH];
  logic bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= 1'b0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < DEPTH; i++) mem[b][i] <= '0;
    end else if (swap_i) begin
      bank_q <= ~bank_q;
      for (int i = 0; i < DEPTH; i++) mem[~bank_q][i] <= '0;
    end else if (we_i) begin
      mem[bank_q][wa_i] <= wd_i;
    end
  end

  assign occ_o  = mem[bank_q][wa_i].drawn;
  assign rd_o   = mem[~bank_q][ra_i];
  assign bank_o = bank_q;
endmodule

// File: rtl/spr_line_render.sv
module spr_line_render
  import spr_line_pkg::*;
#(
  parameter  int SPR_NUM = 32,
  localparam int IDX_W   = $clog2(SPR_NUM)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [COORD_W-1:0] line_i,
  input  logic [IDX_W-1:0]   max_spr_i,
  input  logic               opaque0_i,
  output logic [IDX_W-1:0]   attr_idx_o,
  input  logic [ATTR_W-1:0]  attr_i,
  output logic               pat_re_o,
  output logic [PADDR_W-1:0] pat_addr_o,
  input  logic [PAT_W-1:0]   pat_data_i,
  input  logic [COORD_W-1:0] rd_x_i,
  output logic [PIX_W-1:0]   rd_pix_o,
  output logic               busy_o
);
  typedef enum logic [2:0] {S_IDLE, S_EVAL, S_FETCH, S_CAPT, S_DRAW} st_t;

  st_t                          st_q;
  logic [IDX_W-1:0]             idx_q, max_q;
  logic [COORD_W-1:0]           line_q, prev_x_q, prev_y_q, cur_ex_q;
  logic                         opq_q;
  logic [NAME_W-1:0]            cur_pat_q;
  logic [ROW_W-1:0]             cur_row_q, k_q;
  logic                         cur_big_q, cur_fx_q, cur_prio_q;
  logic [1:0]                   cur_depth_q, cur_pal_q;
  logic [PL_W-1:0]              pl_q, pend_pl_q, last_pl;
  logic                         pend_v_q;
  logic [MAX_PL-1:0][PAT_W-1:0] planes_q;

  spr_attr_t          attr;
  logic [COORD_W-1:0] g_ex, g_ey;
  logic               g_hit;
  logic [ROW_W-1:0]   g_row, last_k;
  logic [MAX_PL-1:0]  col;
  logic [COORD_W:0]   x_sum;
  logic               occ, we, fill_bank;
  pix_t               wd, rd;

  assign attr = spr_attr_t'(attr_i);

  spr_line_geom u_geom (
    .attr_i    (attr),
    .link_en_i (idx_q != '0),
    .prev_x_i  (prev_x_q),
    .prev_y_i  (prev_y_q),
    .line_i    (line_q),
    .ex_o      (g_ex),
    .ey_o      (g_ey),
    .hit_o     (g_hit),
    .row_o     (g_row)
  );

  spr_line_pix u_pix (
    .planes_i (planes_q),
    .k_i      (k_q),
    .big_i    (cur_big_q),
    .flip_x_i (cur_fx_q),
    .col_o    (col)
  );

  always_comb begin
    last_pl = (cur_depth_q == 2'd0) ? PL_W'(0) : (cur_depth_q == 2'd1) ? PL_W'(1) : PL_W'(2);
    last_k  = cur_big_q ? ROW_W'(15) : ROW_W'(7);
    x_sum   = {1'b0, cur_ex_q} + {{(COORD_W+1-ROW_W){1'b0}}, k_q};
    wd      = '{drawn: 1'b1, prio: cur_prio_q, pal: cur_pal_q, col: col};
    // drop right-edge overflow, transparent colour 0, and pixels a lower sprite owns
    we      = (st_q == S_DRAW) && !x_sum[COORD_W] && ((col != '0) || opq_q) && !occ;
  end

  spr_line_buf u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .swap_i (start_i),
    .we_i   (we),
    .wa_i   (x_sum[COORD_W-1:0]),
    .wd_i   (wd),
    .occ_o  (occ),
    .ra_i   (rd_x_i),
    .rd_o   (rd),
    .bank_o (fill_bank)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;
      idx_q <= '0; max_q <= '0; line_q <= '0; opq_q <= 1'b0;
      prev_x_q <= '0; prev_y_q <= '0; cur_ex_q <= '0;
      cur_pat_q <= '0; cur_row_q <= '0; k_q <= '0;
      cur_big_q <= 1'b0; cur_fx_q <= 1'b0; cur_prio_q <= 1'b0;
      cur_depth_q <= '0; cur_pal_q <= '0;
      pl_q <= '0; pend_pl_q <= '0; pend_v_q <= 1'b0;
      planes_q <= '0;
    end else begin
      pend_v_q  <= (st_q == S_FETCH) && !start_i;
      pend_pl_q <= pl_q;
      if (pend_v_q) planes_q[pend_pl_q] <= pat_data_i;
      if (start_i) begin
        st_q <= S_EVAL;
        idx_q <= '0;
        max_q <= max_spr_i;
        line_q <= line_i;
        opq_q <= opaque0_i;
        prev_x_q <= '0;
        prev_y_q <= '0;
      end else begin
        unique case (st_q)
          S_EVAL: begin
            prev_x_q <= g_ex;
            prev_y_q <= g_ey;
            if (g_hit) begin
              cur_ex_q <= g_ex; cur_row_q <= g_row; cur_pat_q <= attr.pat;
              cur_big_q <= attr.big; cur_fx_q <= attr.flip_x; cur_prio_q <= attr.prio;
              cur_depth_q <= attr.depth; cur_pal_q <= attr.pal;
              pl_q <= '0;
              planes_q <= '0;
              st_q <= S_FETCH;
            end else if (idx_q == max_q) begin
              st_q <= S_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          S_FETCH: begin
            if (pl_q == last_pl) st_q <= S_CAPT;
            else pl_q <= pl_q + 1'b1;
          end
          S_CAPT: begin
            k_q <= '0;
            st_q <= S_DRAW;
          end
          S_DRAW: begin
            if (k_q == last_k) begin
              if (idx_q == max_q) st_q <= S_IDLE;
              else begin
                idx_q <= idx_q + 1'b1;
                st_q <= S_EVAL;
              end
            end else begin
              k_q <= k_q + 1'b1;
            end
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  assign attr_idx_o = idx_q;
  assign pat_re_o   = (st_q == S_FETCH);
  assign pat_addr_o = {cur_pat_q, pl_q, cur_row_q};
  assign rd_pix_o   = rd;
  assign busy_o     = (st_q != S_IDLE);
endmodule

// File: rtl/spr_line_chk.sv
module spr_line_chk #(
  parameter int IDX_W  = 5,
  parameter int BUDGET = 800
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             pat_re_o,
  input logic [IDX_W-1:0] attr_idx_o,
  input logic [IDX_W-1:0] max_q,
  input logic             fill_bank
);
  logic [$clog2(BUDGET+1):0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (start_i) cyc_q <= '0;
    else if (busy_o && cyc_q < BUDGET) cyc_q <= cyc_q + 1'b1;
  end

  assert_busy_after_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);

  assert_line_budget_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> cyc_q < BUDGET);

  assert_bank_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(fill_bank));

  assert_bank_swap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> fill_bank != $past(fill_bank));

  assert_pat_read_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_re_o |-> busy_o);

  assert_entry_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> attr_idx_o <= max_q);
endmodule

bind spr_line_render spr_line_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .pat_re_o   (pat_re_o),
  .attr_idx_o (attr_idx_o),
  .max_q      (max_q),
  .fill_bank  (fill_bank)
);

// File: tb/spr_line_render_test.sv
`timescale 1ns/1ps
module spr_line_render_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  line = '0;
  logic [4:0]  max_spr = '0;
  logic        opq = 1'b0;
  logic [4:0]  attr_idx;
  logic [32:0] attr;
  logic        pat_re;
  logic [13:0] pat_addr;
  logic [15:0] pat_data = '0;
  logic [7:0]  rd_x = '0;
  logic [6:0]  rd_pix;
  logic        busy;

  logic [32:0] attr_mem [32];
  int          disp_exp [256];
  string       disp_tag;
  int          checks = 0;
  int          fails = 0;

  always #2.5 clk = ~clk;

  spr_line_render uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .line_i(line),
    .max_spr_i(max_spr), .opaque0_i(opq), .attr_idx_o(attr_idx), .attr_i(attr),
    .pat_re_o(pat_re), .pat_addr_o(pat_addr), .pat_data_i(pat_data),
    .rd_x_i(rd_x), .rd_pix_o(rd_pix), .busy_o(busy)
  );

  assign attr = attr_mem[attr_idx];

  function automatic logic [15:0] pat_fn(logic [13:0] a);
    logic [31:0] h;
    h = {18'd0, a} * 32'd40503 + 32'h5A3C;
    h = h ^ (h >> 7);
    return h[15:0] ^ h[31:16];
  endfunction

  // R12: one-cycle read latency
  always @(posedge clk) pat_data <= pat_fn(pat_addr);

  function automatic logic [32:0] mk(int y, int x, int pat, bit big, bit fx, bit fy,
                                     int depth, int pal, bit prio, bit link);
    return {link, prio, 2'(pal), 2'(depth), fy, fx, big, 8'(pat), 8'(x), 8'(y)};
  endfunction

  task automatic park_all();
    for (int i = 0; i < 32; i++) attr_mem[i] = mk(200, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference of one line
  task automatic model(int ln, int maxs, bit opaque, output int res [256]);
    int px, py;
    px = 0; py = 0;
    for (int x = 0; x < 256; x++) res[x] = 0;
    for (int s = 0; s <= maxs; s++) begin
      logic [32:0] a;
      int ex, ey, dy, sz, row, np, depth;
      a = attr_mem[s];
      ex = a[15:8]; ey = a[7:0];
      if (a[32] && s > 0) begin ex = (ex + px) % 256; ey = (ey + py) % 256; end
      px = ex; py = ey;
      sz = a[24] ? 16 : 8;
      dy = (ln - ey + 256) % 256;
      if (dy >= sz) continue;
      row = a[26] ? sz - 1 - dy : dy;
      depth = a[28:27];
      np = (depth == 0) ? 1 : (depth == 1) ? 2 : 3;
      for (int k = 0; k < sz; k++) begin
        int x, c, colr;
        x = ex + k;
        if (x > 255) continue;
        c = a[25] ? sz - 1 - k : k;
        colr = 0;
        for (int p = 0; p < np; p++) begin
          logic [15:0] w;
          w = pat_fn({a[23:16], 2'(p), 4'(row)});
          colr |= int'(w[15 - c]) << p;
        end
        if ((colr != 0 || opaque) && res[x] == 0)
          res[x] = 64 | (int'(a[31]) << 5) | (int'(a[30:29]) << 3) | colr;
      end
    end
  endtask

  // start a line, compare displayed bank on every clock while the next fills
  task automatic run_line(int ln, int maxs, bit opaque, string tag);
    int cyc;
    int nxt [256];
    @(negedge clk);
    line = 8'(ln); max_spr = 5'(maxs); opq = opaque; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    check(busy == 1'b1, "R9 busy after start", int'(busy), 1);
    for (int x = 0; x < 256; x++) begin
      rd_x = 8'(x);
      #1;
      check(int'(rd_pix) == disp_exp[x], {"R8 R13 ", disp_tag}, int'(rd_pix), disp_exp[x]);
      if (busy) cyc++;
      @(negedge clk);
    end
    while (busy && cyc < 2000) begin cyc++; @(negedge clk); end
    check(cyc < 800, "R9 line budget", cyc, 800);
    model(ln, maxs, opaque, nxt);
    disp_exp = nxt;
    disp_tag = tag;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    park_all();
    for (int x = 0; x < 256; x++) disp_exp[x] = 0;
    disp_tag = "R11 reset";
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R11 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R11 idle after reset", int'(busy), 0);

    // R2 R4 R12: sizes and depths
    attr_mem[0] = mk(48, 10, 3, 0, 0, 0, 0, 1, 0, 0);
    attr_mem[1] = mk(40, 40, 7, 1, 0, 0, 1, 2, 1, 0);
    attr_mem[2] = mk(45, 80, 9, 1, 0, 0, 2, 3, 0, 0);
    attr_mem[3] = mk(50, 120, 11, 1, 0, 0, 3, 0, 1, 0);
    run_line(50, 31, 0, "R2 R4 R12 sizes depths");

    // R3: flips
    attr_mem[0] = mk(48, 10, 3, 0, 1, 1, 0, 1, 0, 0);
    attr_mem[1] = mk(40, 40, 7, 1, 1, 0, 1, 2, 1, 0);
    attr_mem[2] = mk(45, 80, 9, 1, 0, 1, 2, 3, 0, 0);
    attr_mem[3] = mk(50, 120, 11, 1, 1, 1, 3, 0, 1, 0);
    run_line(50, 31, 0, "R3 flips");

    // R5: colour 0 drawn
    run_line(50, 31, 1, "R5 opaque colour 0");

    // R7: overlap, lower number wins
    park_all();
    for (int i = 0; i < 4; i++) attr_mem[i] = mk(44, 20 + 2 * i, 20 + i, 1, 0, 0, 2, i, i % 2, 0);
    run_line(50, 31, 0, "R7 overlap");
    run_line(50, 31, 1, "R7 R5 overlap opaque");

    // R6: link chain
    park_all();
    attr_mem[5] = mk(40, 30, 4, 0, 0, 0, 1, 1, 0, 0);
    attr_mem[6] = mk(2, 20, 5, 0, 0, 0, 1, 2, 0, 1);
    attr_mem[7] = mk(2, 20, 6, 1, 0, 0, 2, 3, 0, 1);
    attr_mem[0] = mk(200, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    run_line(45, 31, 1, "R6 link chain");

    // R1: all 32 on one line, then a lower highest entry
    for (int i = 0; i < 32; i++) attr_mem[i] = mk(48, i * 8, i, 0, 0, 0, 0, i % 4, 0, 0);
    run_line(51, 31, 1, "R1 all sprites");
    run_line(51, 9, 1, "R1 max entry 9");

    // R10: right-edge clip and vertical wrap
    park_all();
    attr_mem[0] = mk(250, 250, 13, 1, 0, 0, 2, 1, 0, 0);
    attr_mem[1] = mk(252, 100, 14, 0, 0, 1, 1, 2, 1, 0);
    run_line(3, 31, 1, "R10 clip wrap");

    // worst case: all 32 at 16x16 with 3 planes
    for (int i = 0; i < 32; i++) attr_mem[i] = mk(60, i * 7, i + 40, 1, i % 2, 0, 2, 1, 0, 0);
    run_line(65, 31, 0, "R9 R1 worst case");

    park_all();
    run_line(0, 31, 0, "R8 flush");
    run_line(0, 31, 0, "R8 empty");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule